// File: doc/BRIEF.md
# FP/Integer Register Move Unit

This block carries out raw bit moves between a general-purpose register file and a floating-point/vector register file. It holds both files: 32 entries of 64 bits for general-purpose data and 32 entries of 128 bits for floating-point data. It takes one 32-bit instruction word per cycle from the floating-point/integer instruction class, together with a valid strobe. It decodes the word and writes the destination register on the next rising clock edge. No value is converted: the bits are copied as they are.

The block supports three sizes. A 32-bit move uses the low word. A 64-bit move uses the low doubleword. A high-half move uses bits 127:64 of the floating-point register. Encodings in the class that ask for a real numeric conversion raise a not-handled flag. Raw-move encodings with a bad size combination raise an undefined-instruction flag. Neither flagged case changes any register.

A preload port fills general-purpose registers, since data can enter the block in no other way. Two combinational debug ports read any entry of either file.

Top module: `fpgp_move_unit`

## Requirements
- R1: With `instr_valid` high, the word is a raw move only when bit 29 is 0, bits 20:19 are less than 2 and bits 18:16 are greater than 5. Every other valid word raises `unhandled` in the same cycle and writes no register.
- R2: A raw move forms the key {bit 31, bits 23:22, bit 19}. Only the key values 0x0 (32-bit), 0xA (64-bit) and 0xD (high half) are legal. Any other key raises `undef` in the same cycle and writes no register. `undef` and `unhandled` are never high together.
- R3: Bit 16 selects the direction. When it is 1, the general-purpose register given by bits 9:5 goes to the floating-point register given by bits 4:0. When it is 0, the floating-point register given by bits 9:5 goes to the general-purpose register given by bits 4:0.
- R4: A 32-bit move into a floating-point register writes the source's bits 31:0, zero-extended, into bits 63:0, and writes zero into bits 127:64.
- R5: A 64-bit move into a floating-point register writes the whole source into bits 63:0 and writes zero into bits 127:64.
- R6: A high-half move into a floating-point register writes the source into bits 127:64 and leaves bits 63:0 unchanged.
- R7: A 32-bit move out of a floating-point register writes its bits 31:0, zero-extended to 64 bits.
- R8: A 64-bit move out of a floating-point register writes its bits 63:0.
- R9: A high-half move out of a floating-point register writes its bits 127:64.
- R10: General-purpose index 31 always reads as zero, and writes to it from a move or from the preload port are ignored.
- R11: A move takes one clock. The result appears on the debug read ports in the cycle after the rising edge that follows the valid instruction.
- R12: A synchronous active-high `rst` clears every entry of both files to zero.
- R13: `gp_ld_en` writes `gp_ld_data` into general-purpose entry `gp_ld_idx` on the rising edge. If a move writes the same entry in the same cycle, the move's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| undef | output | 1 | Illegal size combination for a raw move |
| unhandled | output | 1 | Conversion subtype, not executed here |
| gp_ld_en | input | 1 | Preload write enable |
| gp_ld_idx | input | 5 | Preload target index |
| gp_ld_data | input | 64 | Preload value |
| gp_dbg_idx | input | 5 | General-purpose debug read index |
| gp_dbg_data | output | 64 | General-purpose debug read value |
| fp_dbg_idx | input | 5 | Floating-point debug read index |
| fp_dbg_data | output | 128 | Floating-point debug read value |

## Verification
The sources are preloaded with values that differ in every 32-bit word. This means a move that takes the wrong word, skips zero-extension or fails to clear the high half gives a different result. High-half moves go into registers whose low half was already written, which tells a true merge apart from an overwrite. Each illegal key is tried on its own, as are each conversion trigger (bit 29 set, rmode 2 or 3, opcode 5 or lower) and a garbage word with the strobe low, so that each decode term is checked by itself. Moves and preloads that touch index 31, a preload and a move aimed at the same entry, and a reset in the middle of the run cover the write-priority rules and the reset rule.

// File: rtl/fpgp_pkg.sv
package fpgp_pkg;
    localparam int NREG  = 32;
    localparam int AW    = $clog2(NREG);
    localparam int GP_W  = 64;
    localparam int FP_W  = 2 * GP_W;
    localparam int SW    = GP_W / 2;

    typedef enum logic [1:0] {
        SZ_W32 = 2'd0,
        SZ_X64 = 2'd1,
        SZ_HI  = 2'd2
    } mv_size_e;

    typedef struct packed {
        logic           move_ok;
        logic           to_fp;
        mv_size_e       size;
        logic [AW-1:0]  dst;
        logic [AW-1:0]  src;
        logic           undef;
        logic           unhandled;
    } mv_dec_t;
endpackage

// File: rtl/fpgp_decode.sv
module fpgp_decode
    import fpgp_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] instr,
    output mv_dec_t     dec
);
    logic       f_sf, f_s;
    logic [2:0] f_op;
    logic [1:0] f_rm, f_ty;
    logic [3:0] key;
    logic       raw, legal;
    logic       unused_ok;

    assign f_sf = instr[31];
    assign f_s  = instr[29];
    assign f_ty = instr[23:22];
    assign f_rm = instr[20:19];
    assign f_op = instr[18:16];
    assign unused_ok = ^{instr[30], instr[28:24], instr[21], instr[15:10]};

    always_comb begin
        raw   = !f_s && (f_rm < 2'd2) && (f_op > 3'd5);
        key   = {f_sf, f_ty, f_rm[0]};
        legal = (key == 4'h0) || (key == 4'hA) || (key == 4'hD);
        dec.move_ok   = valid && raw && legal;
        dec.to_fp     = f_op[0];
        dec.size      = mv_size_e'(f_ty);
        dec.dst       = instr[AW-1:0];
        dec.src       = instr[AW+4:5];
        dec.undef     = valid && raw && !legal;
        dec.unhandled = valid && !raw;
    end
endmodule

// File: rtl/fpgp_gp_regfile.sv
module fpgp_gp_regfile #(
    parameter int N  = 32,
    parameter int W  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data
);
    localparam logic [IW-1:0] ZERO_IDX = IW'(N - 1);

    logic [W-1:0] regs_d [N];
    logic [W-1:0] regs_q [N];

    always_comb begin
        regs_d = regs_q;
        if (ld_en && ld_idx != ZERO_IDX) regs_d[ld_idx] = ld_data;
        if (we && widx != ZERO_IDX)      regs_d[widx]   = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = (ra_idx == ZERO_IDX) ? '0 : regs_q[ra_idx];
    assign rb_data = (rb_idx == ZERO_IDX) ? '0 : regs_q[rb_idx];

    // R10
    zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
        regs_q[ZERO_IDX] == '0);

    // R13
    move_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (we && widx != ZERO_IDX) |=> regs_q[$past(widx)] == $past(wdata));
endmodule

// File: rtl/fpgp_fp_regfile.sv
module fpgp_fp_regfile #(
    parameter int N  = 32,
    parameter int W  = 128,
    localparam int IW = $clog2(N),
    localparam int HW = W / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] regs_d [N];
    logic [W-1:0] regs_q [N];

    always_comb begin
        regs_d = regs_q;
        if (we_lo) regs_d[widx][HW-1:0] = wdata[HW-1:0];
        if (we_hi) regs_d[widx][W-1:HW] = wdata[W-1:HW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

    // R6
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (we_hi && !we_lo) |=> regs_q[$past(widx)][HW-1:0] == $past(regs_q[widx][HW-1:0]));

    // R11
    hi_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we_hi |=> regs_q[$past(widx)][W-1:HW] == $past(wdata[W-1:HW]));
endmodule

// File: rtl/fpgp_move_unit.sv
module fpgp_move_unit
    import fpgp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    output logic            undef,
    output logic            unhandled,
    input  logic            gp_ld_en,
    input  logic [4:0]      gp_ld_idx,
    input  logic [63:0]     gp_ld_data,
    input  logic [4:0]      gp_dbg_idx,
    output logic [63:0]     gp_dbg_data,
    input  logic [4:0]      fp_dbg_idx,
    output logic [127:0]    fp_dbg_data
);
    mv_dec_t          dec;
    logic [GP_W-1:0]  gp_src, gp_wdata;
    logic [FP_W-1:0]  fp_src, fp_wdata;
    logic             gp_we, fp_we_lo, fp_we_hi;

    fpgp_decode u_dec (
        .valid (instr_valid),
        .instr (instr),
        .dec   (dec)
    );

    always_comb begin
        gp_we    = dec.move_ok && !dec.to_fp;
        fp_we_hi = dec.move_ok && dec.to_fp;
        fp_we_lo = fp_we_hi && (dec.size != SZ_HI);
        case (dec.size)
            SZ_W32:  fp_wdata = {{(FP_W-SW){1'b0}}, gp_src[SW-1:0]};
            SZ_X64:  fp_wdata = {{GP_W{1'b0}}, gp_src};
            default: fp_wdata = {gp_src, {GP_W{1'b0}}};
        endcase
        case (dec.size)
            SZ_W32:  gp_wdata = {{(GP_W-SW){1'b0}}, fp_src[SW-1:0]};
            SZ_X64:  gp_wdata = fp_src[GP_W-1:0];
            default: gp_wdata = fp_src[FP_W-1:GP_W];
        endcase
    end

    fpgp_gp_regfile #(.N(NREG), .W(GP_W)) u_gp (
        .clk     (clk),
        .rst     (rst),
        .we      (gp_we),
        .widx    (dec.dst),
        .wdata   (gp_wdata),
        .ld_en   (gp_ld_en),
        .ld_idx  (gp_ld_idx),
        .ld_data (gp_ld_data),
        .ra_idx  (dec.src),
        .ra_data (gp_src),
        .rb_idx  (gp_dbg_idx),
        .rb_data (gp_dbg_data)
    );

    fpgp_fp_regfile #(.N(NREG), .W(FP_W)) u_fp (
        .clk     (clk),
        .rst     (rst),
        .we_lo   (fp_we_lo),
        .we_hi   (fp_we_hi),
        .widx    (dec.dst),
        .wdata   (fp_wdata),
        .ra_idx  (dec.src),
        .ra_data (fp_src),
        .rb_idx  (fp_dbg_idx),
        .rb_data (fp_dbg_data)
    );

    assign undef     = dec.undef;
    assign unhandled = dec.unhandled;

    // R2
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({undef, unhandled}));

    // R1
    flagged_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (undef || unhandled) |-> !(gp_we || fp_we_lo || fp_we_hi));
endmodule

// File: tb/fpgp_move_unit_tb_top.sv
`timescale 1ns/1ps
module fpgp_move_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         instr_valid;
    logic [31:0]  instr;
    logic         undef, unhandled;
    logic         gp_ld_en;
    logic [4:0]   gp_ld_idx;
    logic [63:0]  gp_ld_data;
    logic [4:0]   gp_dbg_idx;
    logic [63:0]  gp_dbg_data;
    logic [4:0]   fp_dbg_idx;
    logic [127:0] fp_dbg_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [63:0]  gpm [32];
    logic [127:0] fpm [32];

    always #2 clk = ~clk;

    fpgp_move_unit dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .undef(undef), .unhandled(unhandled),
        .gp_ld_en(gp_ld_en), .gp_ld_idx(gp_ld_idx), .gp_ld_data(gp_ld_data),
        .gp_dbg_idx(gp_dbg_idx), .gp_dbg_data(gp_dbg_data),
        .fp_dbg_idx(fp_dbg_idx), .fp_dbg_data(fp_dbg_data)
    );

    function automatic logic [31:0] enc(input int sf, input int s, input int ty,
                                        input int rm, input int op,
                                        input int rn, input int rd);
        logic [31:0] w;
        w = '0;
        w[31] = sf[0]; w[29] = s[0]; w[28:24] = 5'b11110;
        w[23:22] = ty[1:0]; w[21] = 1'b1; w[20:19] = rm[1:0];
        w[18:16] = op[2:0]; w[9:5] = rn[4:0]; w[4:0] = rd[4:0];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 32; i++) begin gpm[i] = '0; fpm[i] = '0; end
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < 32; i++) begin
            gp_dbg_idx = 5'(i); fp_dbg_idx = 5'(i);
            #0.1;
            chk({tag, " gp"}, {64'd0, gp_dbg_data}, {64'd0, gpm[i]});
            chk({tag, " fp"}, fp_dbg_data, fpm[i]);
        end
    endtask

    // Drive one cycle of stimulus at a negedge, check flags, update model, compare after edge.
    task automatic cycle(input string tag, input bit v, input logic [31:0] w,
                         input bit le, input int li, input logic [63:0] ld);
        int sf, s, ty, rm, op, rn, rd, key;
        bit raw, legal;
        logic [63:0]  gsrc, gres;
        logic [127:0] fsrc;
        @(negedge clk);
        instr_valid = v; instr = w;
        gp_ld_en = le; gp_ld_idx = 5'(li); gp_ld_data = ld;
        sf = int'(w[31]); s = int'(w[29]); ty = int'(w[23:22]); rm = int'(w[20:19]);
        op = int'(w[18:16]); rn = int'(w[9:5]); rd = int'(w[4:0]);
        raw = (s == 0) && (rm < 2) && (op > 5);
        key = sf * 8 + ty * 2 + (rm % 2);
        legal = (key == 0) || (key == 10) || (key == 13);
        #0.5;
        chk({tag, " unhandled R1"}, {127'd0, unhandled}, {127'd0, v && !raw});
        chk({tag, " undef R2"}, {127'd0, undef}, {127'd0, v && raw && !legal});
        gsrc = (rn == 31) ? 64'd0 : gpm[rn];
        fsrc = fpm[rn];
        if (le && li != 31) gpm[li] = ld;
        if (v && raw && legal) begin
            if (op % 2 == 1) begin
                if (ty == 0)      fpm[rd] = {96'd0, gsrc[31:0]};
                else if (ty == 1) fpm[rd] = {64'd0, gsrc};
                else              fpm[rd][127:64] = gsrc;
            end else begin
                if (ty == 0)      gres = {32'd0, fsrc[31:0]};
                else if (ty == 1) gres = fsrc[63:0];
                else              gres = fsrc[127:64];
                if (rd != 31) gpm[rd] = gres;
            end
        end
        @(negedge clk);
        instr_valid = 1'b0; gp_ld_en = 1'b0; instr = '0;
        compare_all(tag);
    endtask

    initial begin
        #800000;
        n_tests++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr = '0;
        gp_ld_en = 1'b0; gp_ld_idx = '0; gp_ld_data = '0;
        gp_dbg_idx = '0; fp_dbg_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model_clear();
        compare_all("R12 reset");

        for (int i = 1; i <= 5; i++)
            cycle("R13 preload", 0, 32'hFFFF_FFFF, 1, i,
                  {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i * 17)});
        cycle("R10 preload idx31", 0, '0, 1, 31, 64'hDEAD_BEEF_0BAD_F00D);

        cycle("R4 to fp w32", 1, enc(0,0,0,0,7,1,2), 0, 0, '0);
        cycle("R5 to fp x64", 1, enc(1,0,1,0,7,2,3), 0, 0, '0);
        cycle("R6 to fp hi", 1, enc(1,0,2,1,7,4,3), 0, 0, '0);
        cycle("R6 to fp hi over w32", 1, enc(1,0,2,1,7,5,2), 0, 0, '0);
        cycle("R3 R7 from fp w32", 1, enc(0,0,0,0,6,3,6), 0, 0, '0);
        cycle("R8 from fp x64", 1, enc(1,0,1,0,6,3,7), 0, 0, '0);
        cycle("R9 from fp hi", 1, enc(1,0,2,1,6,3,8), 0, 0, '0);
        cycle("R9 from fp hi w32 reg", 1, enc(1,0,2,1,6,2,9), 0, 0, '0);
        cycle("R5 overwrite clears hi", 1, enc(1,0,1,0,7,1,3), 0, 0, '0);
        cycle("R10 move to gp31", 1, enc(1,0,1,0,6,3,31), 0, 0, '0);
        cycle("R10 read gp31", 1, enc(1,0,1,0,7,31,3), 0, 0, '0);

        cycle("R2 sf1 ty0", 1, enc(1,0,0,0,7,1,10), 0, 0, '0);
        cycle("R2 sf0 ty1", 1, enc(0,0,1,0,7,1,10), 0, 0, '0);
        cycle("R2 sf1 ty2 rm0", 1, enc(1,0,2,0,7,1,10), 0, 0, '0);
        cycle("R2 sf1 ty1 rm1", 1, enc(1,0,1,1,6,2,10), 0, 0, '0);
        cycle("R2 sf0 ty3", 1, enc(0,0,3,0,6,2,10), 0, 0, '0);
        cycle("R1 S set", 1, enc(1,1,1,0,7,1,11), 0, 0, '0);
        cycle("R1 rmode2", 1, enc(1,0,1,2,7,1,11), 0, 0, '0);
        cycle("R1 rmode3", 1, enc(0,0,0,3,6,2,11), 0, 0, '0);
        cycle("R1 opcode5", 1, enc(1,0,1,0,5,1,11), 0, 0, '0);
        cycle("R1 opcode0", 1, enc(0,0,0,0,0,2,11), 0, 0, '0);
        cycle("R11 valid low", 0, enc(1,0,1,0,7,1,12), 0, 0, '0);

        cycle("R13 same entry", 1, enc(1,0,1,0,6,3,4), 1, 4, 64'h1111_2222_3333_4444);
        cycle("R13 other entry", 1, enc(0,0,0,0,6,3,13), 1, 14, 64'h7777_8888_9999_AAAA);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        compare_all("R12 mid reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule